// File: doc/BRIEF.md
# Packed Byte Compare Mask Unit

This unit compares two wide vector operands lane by lane, eight bits per lane, and packs one result bit per lane into a 64-bit mask. A 3-bit predicate code picks the relation tested in every lane. A signedness select decides whether each byte is read as a two's-complement number or as a plain magnitude. The unit sits in the execution path of a vector pipeline: the issue logic supplies both operands, the predicate byte, the vector-length select and an optional per-lane gating mask, and the result mask is written to a mask register by logic outside the block.

A vector-length select of 128, 256 or 512 bits sets how many lanes are live. Mask bits above the live lane count always read 0. When gating is enabled, each lane whose gate bit is 0 yields 0 and never keeps an old value. By default the result is registered, with a one-cycle valid handshake. A parameter can remove the register stage so the path becomes purely combinational.

Top module: `byte_cmp_mask_unit`

## Requirements
- R1: Lane j is operand bits 8j+7 down to 8j of each operand, and its result goes to out_mask bit j.
- R2: The low three predicate bits select the relation of operand A's lane to operand B's lane: 0 equal, 1 A less than B, 2 A less than or equal to B, 3 constant 0, 4 not equal, 5 A not less than B, 6 A not less than or equal to B, 7 constant 1.
- R3: Predicate bits 7 to 3 have no effect on the result.
- R4: With is_signed at 1, each byte is read as a two's-complement value from -128 to 127. For example, 0x80 is less than 0x7F.
- R5: With is_signed at 0, each byte is read as an unsigned value from 0 to 255. For example, 0x7F is less than 0x80, and 0xFF is the largest value.
- R6: vlen_sel 0, 1 and 2 give 16, 32 and 64 live lanes, and code 3 behaves as 64. Every out_mask bit at or above the live lane count is 0.
- R7: With wmask_en at 1, every lane whose wmask bit is 0 yields result bit 0.
- R8: With wmask_en at 0, wmask has no effect and every live lane yields its comparison result.
- R9: With the register stage present, out_valid equals in_valid one clock later, and out_mask carries the result for the inputs presented in that earlier cycle. Synchronous active-high rst clears out_valid and out_mask to 0.
- R10: A clock edge with in_valid at 0 leaves out_mask unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs on this cycle hold a compare to perform |
| op_a | input | 512 | First vector operand, byte lanes |
| op_b | input | 512 | Second vector operand, byte lanes |
| pred_imm | input | 8 | Predicate byte; only bits 2:0 matter |
| is_signed | input | 1 | 1 selects two's-complement bytes, 0 unsigned |
| vlen_sel | input | 2 | Live length: 0 = 128, 1 = 256, 2 or 3 = 512 bits |
| wmask_en | input | 1 | Apply the per-lane gating mask |
| wmask | input | 64 | Per-lane gate, bit j gates lane j |
| out_valid | output | 1 | out_mask holds a new result |
| out_mask | output | 64 | One result bit per lane |

## Verification
The main comparison is driven with ramps of byte values whose start and step differ between operands. As a result, each lane sees its own mix of equal, greater and smaller pairs, and the ramps cross 0x7F/0x80 and 0xFF/0x00, where signed and unsigned readings disagree. Uniform fills of 0x80 against 0x7F separate the two signedness modes outright. A single differing lane shows that results land at the right bit position. Predicate bytes with the reserved bits set must match the result of their clean three-bit code. Sweeps of length and gate patterns with the constant-true code expose the live-lane and gating logic on their own, apart from the comparison.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PR_EQ    = 3'd0,
    PR_LT    = 3'd1,
    PR_LE    = 3'd2,
    PR_FALSE = 3'd3,
    PR_NE    = 3'd4,
    PR_GE    = 3'd5,
    PR_GT    = 3'd6,
    PR_TRUE  = 3'd7
  } pred_e;

  // Ordering test: flipping the top bit in signed mode maps two's complement
  // onto an unsigned scale, so one magnitude comparator serves both modes.
  function automatic logic lane_less(input logic [BYTE_W-1:0] a,
                                     input logic [BYTE_W-1:0] b,
                                     input logic              sgn);
    logic [BYTE_W-1:0] ka;
    logic [BYTE_W-1:0] kb;
    ka = {a[BYTE_W-1] ^ sgn, a[BYTE_W-2:0]};
    kb = {b[BYTE_W-1] ^ sgn, b[BYTE_W-2:0]};
    return ka < kb;
  endfunction

  // Base relation picked by the low two code bits, then optionally inverted.
  function automatic logic pred_eval(input logic [1:0] base_sel,
                                     input logic       invert,
                                     input logic       lt,
                                     input logic       eq);
    logic r;
    case (base_sel)
      2'd0:    r = eq;
      2'd1:    r = lt;
      2'd2:    r = lt | eq;
      default: r = 1'b0;
    endcase
    return r ^ invert;
  endfunction

  // Live lane count for a length code, capped at the lanes built.
  function automatic int lanes_for_vlen(input logic [1:0] v, input int max_lanes);
    int n;
    case (v)
      2'd0:    n = 16;
      2'd1:    n = 32;
      default: n = 64;
    endcase
    if (n > max_lanes) n = max_lanes;
    return n;
  endfunction

endpackage

// File: rtl/bcm_pred_decode.sv
module bcm_pred_decode
  import bcm_pkg::*;
(
  input  logic [2:0] code_in,
  output pred_e      pred,
  output logic [1:0] base_sel,
  output logic       invert
);

  always_comb begin
    pred = pred_e'(code_in);
    case (pred)
      PR_EQ:    begin base_sel = 2'd0; invert = 1'b0; end
      PR_LT:    begin base_sel = 2'd1; invert = 1'b0; end
      PR_LE:    begin base_sel = 2'd2; invert = 1'b0; end
      PR_FALSE: begin base_sel = 2'd3; invert = 1'b0; end
      PR_NE:    begin base_sel = 2'd0; invert = 1'b1; end
      PR_GE:    begin base_sel = 2'd1; invert = 1'b1; end
      PR_GT:    begin base_sel = 2'd2; invert = 1'b1; end
      default:  begin base_sel = 2'd3; invert = 1'b1; end
    endcase
  end

endmodule

// File: rtl/bcm_lane_cmp.sv
module bcm_lane_cmp
  import bcm_pkg::*;
#(
  parameter int LANES = 64,
  localparam int DATA_W = LANES * BYTE_W
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              is_signed,
  output logic [LANES-1:0]  lane_eq,
  output logic [LANES-1:0]  lane_lt
);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [BYTE_W-1:0] a_b;
    logic [BYTE_W-1:0] b_b;
    assign a_b        = op_a[j*BYTE_W +: BYTE_W];
    assign b_b        = op_b[j*BYTE_W +: BYTE_W];
    assign lane_eq[j] = (a_b == b_b);
    assign lane_lt[j] = lane_less(a_b, b_b, is_signed);
  end

endmodule

// File: rtl/bcm_lane_gate.sv
module bcm_lane_gate
  import bcm_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic [1:0]       vlen_sel,
  input  logic             wmask_en,
  input  logic [LANES-1:0] wmask,
  output logic [LANES-1:0] lane_enable
);

  int live_count;
  always_comb live_count = lanes_for_vlen(vlen_sel, LANES);

  for (genvar j = 0; j < LANES; j++) begin : g_gate
    logic live;
    assign live           = (j < live_count);
    assign lane_enable[j] = live & (~wmask_en | wmask[j]);
  end

endmodule

// File: rtl/byte_cmp_mask_unit.sv
module byte_cmp_mask_unit
  import bcm_pkg::*;
#(
  parameter int MAX_LANES  = 64,
  parameter bit REGISTERED = 1'b1,
  localparam int DATA_W = MAX_LANES * BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [DATA_W-1:0]    op_a,
  input  logic [DATA_W-1:0]    op_b,
  input  logic [7:0]           pred_imm,
  input  logic                 is_signed,
  input  logic [1:0]           vlen_sel,
  input  logic                 wmask_en,
  input  logic [MAX_LANES-1:0] wmask,
  output logic                 out_valid,
  output logic [MAX_LANES-1:0] out_mask
);

  pred_e                pred;
  logic [1:0]           base_sel;
  logic                 invert;
  logic [MAX_LANES-1:0] lane_eq;
  logic [MAX_LANES-1:0] lane_lt;
  logic [MAX_LANES-1:0] lane_enable;
  logic [MAX_LANES-1:0] hit_vec;

  bcm_pred_decode u_dec (
    .code_in  (pred_imm[2:0]),
    .pred     (pred),
    .base_sel (base_sel),
    .invert   (invert)
  );

  bcm_lane_cmp #(.LANES(MAX_LANES)) u_cmp (
    .op_a      (op_a),
    .op_b      (op_b),
    .is_signed (is_signed),
    .lane_eq   (lane_eq),
    .lane_lt   (lane_lt)
  );

  bcm_lane_gate #(.LANES(MAX_LANES)) u_gate (
    .vlen_sel    (vlen_sel),
    .wmask_en    (wmask_en),
    .wmask       (wmask),
    .lane_enable (lane_enable)
  );

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_hit
    assign hit_vec[j] = lane_enable[j] & pred_eval(base_sel, invert, lane_lt[j], lane_eq[j]);
  end

  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        out_mask  <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) out_mask <= hit_vec;
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign out_mask  = hit_vec;
  end

endmodule

// File: rtl/bcm_checker.sv
module bcm_checker
  import bcm_pkg::*;
#(
  parameter int MAX_LANES  = 64,
  parameter bit REGISTERED = 1'b1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [7:0]           pred_imm,
  input logic [1:0]           vlen_sel,
  input logic                 wmask_en,
  input logic [MAX_LANES-1:0] wmask,
  input logic                 out_valid,
  input logic [MAX_LANES-1:0] out_mask,
  input logic [MAX_LANES-1:0] lane_eq,
  input logic [MAX_LANES-1:0] lane_lt
);

  function automatic logic [MAX_LANES-1:0] live_mask(input logic [1:0] v);
    logic [MAX_LANES-1:0] m;
    int n;
    n = lanes_for_vlen(v, MAX_LANES);
    for (int k = 0; k < MAX_LANES; k++) m[k] = (k < n);
    return m;
  endfunction

  // R4/R5: a lane cannot be both equal and strictly less
  assert_eq_lt_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    (lane_eq & lane_lt) == '0);

  if (REGISTERED) begin : g_seq
    assert_upper_clear_R6: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ((out_mask & ~live_mask($past(vlen_sel))) == '0));

    assert_zeroing_R7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(wmask_en)) |-> ((out_mask & ~$past(wmask)) == '0));

    assert_false_code_R2: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(pred_imm[2:0]) == 3'd3) |-> (out_mask == '0));

    assert_true_code_R8: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(pred_imm[2:0]) == 3'd7 && !$past(wmask_en))
        |-> (out_mask == live_mask($past(vlen_sel))));

    assert_reserved_false_R3: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(pred_imm[7:3]) != 5'd0 && $past(pred_imm[2:0]) == 3'd3)
        |-> (out_mask == '0));

    assert_valid_rise_R9: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

    assert_valid_fall_R9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_mask));
  end

endmodule

bind byte_cmp_mask_unit bcm_checker #(
  .MAX_LANES  (MAX_LANES),
  .REGISTERED (REGISTERED)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .pred_imm  (pred_imm),
  .vlen_sel  (vlen_sel),
  .wmask_en  (wmask_en),
  .wmask     (wmask),
  .out_valid (out_valid),
  .out_mask  (out_mask),
  .lane_eq   (lane_eq),
  .lane_lt   (lane_lt)
);

// File: tb/sim_byte_cmp_mask_unit.sv
module sim_byte_cmp_mask_unit;

  localparam int NL = 64;
  localparam int DW = NL * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] op_a = '0;
  logic [DW-1:0] op_b = '0;
  logic [7:0]    pred_imm = '0;
  logic          is_signed = 1'b0;
  logic [1:0]    vlen_sel = '0;
  logic          wmask_en = 1'b0;
  logic [NL-1:0] wmask = '0;
  logic          out_valid;
  logic [NL-1:0] out_mask;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  byte_cmp_mask_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .pred_imm(pred_imm), .is_signed(is_signed), .vlen_sel(vlen_sel),
    .wmask_en(wmask_en), .wmask(wmask), .out_valid(out_valid), .out_mask(out_mask)
  );

  typedef struct packed {
    logic [7:0]  pred;
    logic        sgn;
    logic [1:0]  vlen;
    logic        wen;
    logic [7:0]  a0;
    logic [7:0]  as;
    logic [7:0]  b0;
    logic [7:0]  bs;
    logic [63:0] wm;
  } vec_t;

  // Operand lane j = base + step*j (mod 256); ramps cross 7F/80 and FF/00.
  localparam vec_t TBL [16] = '{
    '{8'h00, 1'b0, 2'd2, 1'b0, 8'h00, 8'h01, 8'h00, 8'h01, 64'h0},
    '{8'h00, 1'b1, 2'd2, 1'b0, 8'h70, 8'h01, 8'h7F, 8'h00, 64'h0},
    '{8'h01, 1'b1, 2'd2, 1'b0, 8'h60, 8'h03, 8'h80, 8'h00, 64'h0},
    '{8'h01, 1'b0, 2'd2, 1'b0, 8'h60, 8'h03, 8'h80, 8'h00, 64'h0},
    '{8'h02, 1'b1, 2'd1, 1'b0, 8'hF0, 8'h01, 8'h00, 8'h00, 64'h0},
    '{8'h02, 1'b0, 2'd1, 1'b0, 8'hF0, 8'h01, 8'h00, 8'h00, 64'h0},
    '{8'h03, 1'b1, 2'd2, 1'b0, 8'h11, 8'h05, 8'h22, 8'h07, 64'h0},
    '{8'h04, 1'b0, 2'd0, 1'b0, 8'h7C, 8'h01, 8'h80, 8'hFF, 64'h0},
    '{8'h05, 1'b1, 2'd2, 1'b1, 8'h00, 8'h04, 8'h80, 8'h04, 64'hF0F0_3C3C_0FF0_AAAA},
    '{8'h05, 1'b0, 2'd2, 1'b1, 8'h00, 8'h04, 8'h80, 8'h04, 64'hF0F0_3C3C_0FF0_AAAA},
    '{8'h06, 1'b1, 2'd3, 1'b0, 8'hFF, 8'hFF, 8'h00, 8'h01, 64'h0},
    '{8'h06, 1'b0, 2'd2, 1'b0, 8'hFF, 8'hFF, 8'h00, 8'h01, 64'h0},
    '{8'h07, 1'b0, 2'd0, 1'b1, 8'h01, 8'h02, 8'h03, 8'h04, 64'h1234_5678_9ABC_DEF0},
    '{8'hFA, 1'b1, 2'd2, 1'b0, 8'h7F, 8'h01, 8'h80, 8'h00, 64'h0},
    '{8'h5A, 1'b0, 2'd2, 1'b0, 8'h7F, 8'h01, 8'h80, 8'h00, 64'h0},
    '{8'hE4, 1'b1, 2'd1, 1'b1, 8'h30, 8'h09, 8'h30, 8'h0B, 64'h0000_0000_FFFF_0F0F}
  };

  function automatic logic [DW-1:0] ramp(input logic [7:0] base, input logic [7:0] step);
    logic [DW-1:0] v;
    for (int j = 0; j < NL; j++) v[j*8 +: 8] = base + step * j[7:0];
    return v;
  endfunction

  // Independent reference: integers with explicit sign extension.
  function automatic logic [NL-1:0] ref_mask(input logic [7:0] pr, input logic sg,
      input logic [1:0] vl, input logic we, input logic [NL-1:0] wm,
      input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [NL-1:0] m;
    int live;
    live = (vl == 2'd0) ? 16 : (vl == 2'd1) ? 32 : 64;
    m = '0;
    for (int j = 0; j < NL; j++) begin
      int x, y;
      bit r;
      x = int'(a[j*8 +: 8]);
      y = int'(b[j*8 +: 8]);
      if (sg && x > 127) x = x - 256;
      if (sg && y > 127) y = y - 256;
      case (pr % 8)
        0: r = (x == y);
        1: r = (x < y);
        2: r = (x <= y);
        3: r = 0;
        4: r = (x != y);
        5: r = (x >= y);
        6: r = (x > y);
        default: r = 1;
      endcase
      if (j < live && (!we || wm[j])) m[j] = r;
    end
    return m;
  endfunction

  task automatic chk(input string req, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] pr, input logic sg, input logic [1:0] vl,
      input logic we, input logic [NL-1:0] wm, input logic [DW-1:0] a, input logic [DW-1:0] b);
    @(negedge clk);
    in_valid = 1'b1; pred_imm = pr; is_signed = sg; vlen_sel = vl;
    wmask_en = we; wmask = wm; op_a = a; op_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : main
    logic [NL-1:0] held;
    repeat (3) @(negedge clk);
    chk("R9 reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R9 reset out_mask", out_mask, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < 16; i++) begin
      logic [DW-1:0] a, b;
      a = ramp(TBL[i].a0, TBL[i].as);
      b = ramp(TBL[i].b0, TBL[i].bs);
      run(TBL[i].pred, TBL[i].sgn, TBL[i].vlen, TBL[i].wen, TBL[i].wm, a, b);
      chk("R9 valid after table vector", {63'd0, out_valid}, 64'd1);
      chk("R2 table vector", out_mask,
          ref_mask(TBL[i].pred, TBL[i].sgn, TBL[i].vlen, TBL[i].wen, TBL[i].wm, a, b));
    end

    // R1: only lane 5 matches
    run(8'h00, 1'b0, 2'd2, 1'b0, '0, {NL{8'h00}}, {NL{8'h01}} & ~(512'hFF << 40));
    chk("R1 single lane position", out_mask, 64'h0000_0000_0000_0020);

    // R4/R5: 0x80 vs 0x7F
    run(8'h01, 1'b1, 2'd2, 1'b0, '0, {NL{8'h80}}, {NL{8'h7F}});
    chk("R4 signed 80<7F", out_mask, {NL{1'b1}});
    run(8'h01, 1'b0, 2'd2, 1'b0, '0, {NL{8'h80}}, {NL{8'h7F}});
    chk("R5 unsigned 80<7F false", out_mask, 64'd0);
    run(8'h06, 1'b0, 2'd2, 1'b0, '0, {NL{8'hFF}}, {NL{8'h00}});
    chk("R5 unsigned FF>00", out_mask, {NL{1'b1}});

    // R3: reserved bits set, code 1
    run(8'hF9, 1'b1, 2'd2, 1'b0, '0, {NL{8'h80}}, {NL{8'h7F}});
    chk("R3 reserved bits ignored", out_mask, {NL{1'b1}});

    // R6: lengths under constant-true
    run(8'h07, 1'b0, 2'd0, 1'b0, '0, '0, '0);
    chk("R6 length 128", out_mask, 64'h0000_0000_0000_FFFF);
    run(8'h07, 1'b0, 2'd1, 1'b0, '0, '0, '0);
    chk("R6 length 256", out_mask, 64'h0000_0000_FFFF_FFFF);
    run(8'h07, 1'b0, 2'd3, 1'b0, '0, '0, '0);
    chk("R6 length code 3", out_mask, {NL{1'b1}});

    // R7/R8: gating
    run(8'h07, 1'b0, 2'd2, 1'b1, 64'hA5A5_0000_FFFF_0001, '0, '0);
    chk("R7 zeroing by gate", out_mask, 64'hA5A5_0000_FFFF_0001);
    run(8'h07, 1'b0, 2'd2, 1'b0, 64'h0, '0, '0);
    chk("R8 gate disabled", out_mask, {NL{1'b1}});

    // R10: idle cycle with changed inputs leaves result
    held = out_mask;
    @(negedge clk);
    pred_imm = 8'h03; vlen_sel = 2'd0; op_a = {NL{8'h55}};
    @(negedge clk);
    chk("R10 hold while idle", out_mask, held);
    chk("R9 valid drops", {63'd0, out_valid}, 64'd0);

    // R9: reset mid-run clears
    run(8'h07, 1'b0, 2'd2, 1'b0, '0, '0, '0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 reset clears mask", out_mask, 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule